// File: doc/BRIEF.md
# Mixed Page-Size Translation Cache

This block holds a small, fully associative set of recent virtual-to-physical page translations and sits in front of a page table walker. A lookup presents a 48-bit virtual address together with two flags: whether the access is a write, and whether it comes from user mode. In the same cycle the block returns either a hit with the physical address, a protection fault, or a walk request. On a walk request the walker is expected to fetch the translation and return it on the fill port. The block installs the returned translation, and the retried access then hits.

Every entry carries a page-size tag. The tag sets how many upper virtual address bits are compared: bits 47:12 for a 4 KB page, bits 47:21 for a 2 MB page, and bits 47:30 for a 1 GB page. A single large-page entry therefore stands in for 512 or 262144 small-page entries. Each entry also stores three bits: a writable bit, a user-accessible bit and a dirty bit. Maintenance uses two inputs: a one-cycle flush of every entry, and an invalidate that removes the entries covering one given address.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses and raises walk_req.
- R2: A lookup that hits sets lk_hit in the same cycle. lk_pa is then the stored frame number shifted left by 12, with its low bits replaced by the virtual address bits for the page size. The size codes are 0 for 4 KB, 1 for 2 MB and 2 for 1 GB, and the replaced bits are 11:0, 20:0 and 29:0 respectively.
- R3: An entry matches a lookup when the virtual address bits agree above the page offset: bits 47:12 for size 0, 47:21 for size 1 and 47:30 for size 2. When several entries match, the lowest-numbered one is used.
- R4: A matching lookup raises lk_fault, with neither lk_hit nor walk_req, in two cases: the access is a user access and the entry's user bit is 0, or the access is a write and the entry's write bit is 0.
- R5: A permitted write that matches an entry whose dirty bit is 0 is reported as a miss (walk_req=1, lk_hit=0). A read of the same entry hits.
- R6: Exactly one of lk_hit, lk_fault and walk_req is high while lk_valid is high. All three are low, and lk_pa is zero, while lk_valid is low.
- R7: A fill is visible to lookups from the cycle after fill_valid. A lookup in the fill's own cycle sees the old contents.
- R8: If fill_va matches an existing entry, that entry is overwritten. Otherwise the lowest-numbered invalid entry is used. When no entry is invalid, the entry at a round-robin pointer is replaced; the pointer starts at 0 and advances by one, wrapping, on each such replacement.
- R9: inval_valid clears every valid entry whose range contains inval_va and leaves all other entries untouched. A fill in the same cycle is still installed.
- R10: flush clears every entry in one cycle, overrides a fill in the same cycle and returns the replacement pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present |
| lk_va | input | VA_W | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup is a user-mode access |
| lk_hit | output | 1 | Translation found and permitted |
| lk_fault | output | 1 | Protection fault on a matching entry |
| lk_pa | output | PA_W | Physical address on a hit, else zero |
| walk_req | output | 1 | Miss; the walker should fetch lk_va |
| fill_valid | input | 1 | Install a translation |
| fill_va | input | VA_W | Virtual address of the fill |
| fill_ppn | input | PA_W-12 | Physical frame number of the fill |
| fill_size | input | 2 | Page size: 0 is 4 KB, 1 is 2 MB, 2 is 1 GB |
| fill_write | input | 1 | Page is writable |
| fill_user | input | 1 | Page is user-accessible |
| fill_dirty | input | 1 | Page is already dirty |
| inval_valid | input | 1 | Invalidate entries covering inval_va |
| inval_va | input | VA_W | Address to invalidate |
| flush | input | 1 | Clear all entries |

## Verification
The bench targets the address offset boundaries of each page size. A mask that is wrong by one bit makes a 2 MB entry either miss on a neighbouring 4 KB page or hit on the next 2 MB page. It also corrupts the high offset bits of lk_pa. A clean-page write that hits instead of missing would let a page be modified while its dirty bit stays clear. A refill that lands in a new slot instead of the matching one would leave the stale clean entry first in priority, so the retried write would miss forever. Further checks cover a fill and a lookup of the same page in one cycle, a flush that coincides with a fill, and round-robin eviction once all slots are full. A pointer that starts at the wrong index or never advances would evict a page that should have stayed resident.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic [PA_W-1:0]   lk_pa,
  output logic              walk_req,
  input  logic              fill_valid,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [PA_W-13:0]  fill_ppn,
  input  logic [1:0]        fill_size,
  input  logic              fill_write,
  input  logic              fill_user,
  input  logic              fill_dirty,
  input  logic              inval_valid,
  input  logic [VA_W-1:0]   inval_va,
  input  logic              flush
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = VA_W - 12;
  localparam int PPN_W = PA_W - 12;

  logic [ENTRIES-1:0] e_vld, e_wr, e_usr, e_dty;
  logic [1:0]         e_sz  [ENTRIES];
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [IDX_W-1:0]   rr;

  function automatic logic [17:0] offm(input logic [1:0] sz);
    case (sz)
      2'd1:    offm = 18'h001FF;
      2'd2:    offm = 18'h3FFFF;
      default: offm = 18'h00000;
    endcase
  endfunction

  function automatic logic covers(input logic [VPN_W-1:0] tag, input logic [1:0] sz,
                                  input logic [VA_W-1:0] va);
    logic [VPN_W-1:0] m;
    m = ~{{(VPN_W-18){1'b0}}, offm(sz)};
    covers = ((va[VA_W-1:12] ^ tag) & m) == '0;
  endfunction

  logic [ENTRIES-1:0] lk_m, fl_m, iv_m;
  logic [IDX_W-1:0]   lk_sel, fl_sel, free_sel, victim;

  always_comb begin
    lk_sel = '0; fl_sel = '0; free_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_m[i] = e_vld[i] && covers(e_vpn[i], e_sz[i], lk_va);
      fl_m[i] = e_vld[i] && covers(e_vpn[i], e_sz[i], fill_va);
      iv_m[i] = e_vld[i] && covers(e_vpn[i], e_sz[i], inval_va);
    end
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (lk_m[i])   lk_sel   = IDX_W'(i);
      if (fl_m[i])   fl_sel   = IDX_W'(i);
      if (!e_vld[i]) free_sel = IDX_W'(i);
    end
  end

  wire evict = fill_valid && !(|fl_m) && (&e_vld);
  assign victim = (|fl_m) ? fl_sel : ((&e_vld) ? rr : free_sel);

  wire        matched = lk_valid && (|lk_m);
  wire        deny    = (lk_user && !e_usr[lk_sel]) || (lk_write && !e_wr[lk_sel]);
  wire [17:0] lm      = offm(e_sz[lk_sel]);
  wire [PPN_W-1:0] ppn_o = {e_ppn[lk_sel][PPN_W-1:18],
                            (e_ppn[lk_sel][17:0] & ~lm) | (lk_va[29:12] & lm)};

  assign lk_fault = matched && deny;
  assign lk_hit   = matched && !deny && !(lk_write && !e_dty[lk_sel]);
  assign walk_req = lk_valid && !lk_hit && !lk_fault;
  assign lk_pa    = lk_hit ? {ppn_o, lk_va[11:0]} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= '0;
      rr    <= '0;
    end else begin
      if (inval_valid) e_vld <= e_vld & ~iv_m;
      if (fill_valid) begin
        e_vld[victim] <= 1'b1;
        e_wr[victim]  <= fill_write;
        e_usr[victim] <= fill_user;
        e_dty[victim] <= fill_dirty;
        e_sz[victim]  <= fill_size;
        e_vpn[victim] <= fill_va[VA_W-1:12];
        e_ppn[victim] <= fill_ppn;
      end
      if (evict) rr <= (rr == IDX_W'(ENTRIES-1)) ? '0 : rr + 1'b1;
      if (flush) begin
        e_vld <= '0;
        rr    <= '0;
      end
    end
  end

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, lk_fault, walk_req}) == 1);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit && !lk_fault && !walk_req && lk_pa == '0);
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit && !lk_fault);
  p_fill_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !flush |=> !(lk_valid && !lk_write && !lk_user && lk_va == $past(fill_va)) || lk_hit);
  p_inval_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid && !fill_valid && !flush |=> !(lk_valid && lk_va == $past(inval_va)) || walk_req);
  p_ptr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rr <= IDX_W'(ENTRIES-1));
  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[11:0] == lk_va[11:0]);
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  localparam int N = 32;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [47:0] lk_va = '0, fill_va = '0, inval_va = '0;
  logic fill_valid = 0, fill_write = 0, fill_user = 0, fill_dirty = 0;
  logic [27:0] fill_ppn = '0;
  logic [1:0] fill_size = '0;
  logic inval_valid = 0, flush = 0;
  logic lk_hit, lk_fault, walk_req;
  logic [39:0] lk_pa;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  xlat_cache #(.ENTRIES(N), .VA_W(48), .PA_W(40)) uut (.*);

  logic        m_vld [N];
  logic [35:0] m_vpn [N];
  logic [1:0]  m_sz  [N];
  logic [27:0] m_ppn [N];
  logic        m_w [N], m_u [N], m_d [N];
  int          m_rr;

  function automatic int shamt(input logic [1:0] sz);
    return (sz == 2'd1) ? 21 : (sz == 2'd2) ? 30 : 12;
  endfunction

  function automatic bit mmatch(input int i, input logic [47:0] va);
    int s = shamt(m_sz[i]);
    return m_vld[i] && ((va >> s) == ({m_vpn[i], 12'h000} >> s));
  endfunction

  function automatic logic [42:0] mlook(input logic v, input logic [47:0] va,
                                        input logic wr, input logic us);
    int idx = -1;
    logic [39:0] mask;
    if (!v) return '0;
    for (int i = 0; i < N; i++) if (idx < 0 && mmatch(i, va)) idx = i;
    if (idx < 0) return {3'b001, 40'h0};
    if ((us && !m_u[idx]) || (wr && !m_w[idx])) return {3'b010, 40'h0};
    if (wr && !m_d[idx]) return {3'b001, 40'h0};
    mask = (40'd1 << shamt(m_sz[idx])) - 40'd1;
    return {3'b100, ({m_ppn[idx], 12'h000} & ~mask) | (va[39:0] & mask)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [47:0] lva, input logic lw, input logic lu,
                      input logic fv, input logic [47:0] fva, input logic [27:0] fp,
                      input logic [1:0] fs, input logic fw, input logic fu, input logic fd,
                      input logic iv, input logic [47:0] iva, input logic fl, input string tag);
    logic [42:0] exp;
    int hit_i, vic;
    @(negedge clk);
    lk_valid = lv; lk_va = lva; lk_write = lw; lk_user = lu;
    fill_valid = fv; fill_va = fva; fill_ppn = fp; fill_size = fs;
    fill_write = fw; fill_user = fu; fill_dirty = fd;
    inval_valid = iv; inval_va = iva; flush = fl;
    #1;
    exp = mlook(lv, lva, lw, lu);
    check(tag, {21'h0, lk_hit, lk_fault, walk_req, lk_pa}, {21'h0, exp});
    @(posedge clk);
    hit_i = -1; vic = -1;
    for (int i = 0; i < N; i++) if (hit_i < 0 && mmatch(i, fva)) hit_i = i;
    for (int i = 0; i < N; i++) if (vic < 0 && !m_vld[i]) vic = i;
    if (hit_i >= 0) vic = hit_i;
    else if (vic < 0) begin vic = m_rr; if (fv) m_rr = (m_rr + 1) % N; end
    if (iv) for (int i = 0; i < N; i++) if (mmatch(i, iva)) m_vld[i] = 0;
    if (fv) begin
      m_vld[vic] = 1; m_vpn[vic] = fva[47:12]; m_sz[vic] = fs; m_ppn[vic] = fp;
      m_w[vic] = fw; m_u[vic] = fu; m_d[vic] = fd;
    end
    if (fl) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
      m_rr = 0;
    end
  endtask

  task automatic look(input logic [47:0] va, input logic wr, input logic us, input string tag);
    step(1, va, wr, us, 0, '0, '0, 0, 0, 0, 0, 0, '0, 0, tag);
  endtask

  task automatic fill(input logic [47:0] va, input logic [27:0] p, input logic [1:0] sz,
                      input logic w, input logic u, input logic d);
    step(0, '0, 0, 0, 1, va, p, sz, w, u, d, 0, '0, 0, "R6");
  endtask

  function automatic logic [47:0] rva();
    logic [47:0] base;
    case ($urandom % 4)
      0: base = 48'h0000_0000_0000;
      1: base = 48'h0000_4000_0000;
      2: base = 48'h7F00_0000_0000;
      default: base = 48'h0012_3400_0000;
    endcase
    return base | 48'($urandom % (1 << 22));
  endfunction

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_rr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    look(48'h0000_1234_5678, 0, 0, "R1");
    look(48'h7F00_0000_0000, 1, 1, "R1");
    // R7: same-cycle fill and lookup of the same page
    step(1, 48'h0000_1234_5678, 0, 0, 1, 48'h0000_1234_5000, 28'h00ABC, 0, 1, 1, 1,
         0, '0, 0, "R7");
    look(48'h0000_1234_5678, 0, 0, "R7");
    check("R2", lk_pa, 40'h00_00AB_C678);
    look(48'h0000_1234_6000, 0, 0, "R3");
    // 2 MB page
    fill(48'h0000_4020_0000, 28'h1234600, 1, 0, 0, 1);
    look(48'h0000_402A_BCDE, 0, 0, "R3");
    check("R2", lk_pa, 40'h12_346A_BCDE);
    look(48'h0000_4040_0000, 0, 0, "R3");
    look(48'h0000_401F_FFFF, 0, 0, "R3");
    look(48'h0000_402A_BCDE, 0, 1, "R4");
    look(48'h0000_402A_BCDE, 1, 0, "R4");
    // 1 GB page
    fill(48'h0080_4000_0000, 28'h0ABC0000 >> 0, 2, 1, 1, 1);
    look(48'h0080_7FFF_F123, 1, 1, "R3");
    look(48'h0080_8000_0000, 0, 0, "R3");
    // R5 and R8: clean page, then refill with dirty set
    fill(48'h0000_0009_9000, 28'h00777, 0, 1, 1, 0);
    look(48'h0000_0009_9010, 0, 1, "R5");
    look(48'h0000_0009_9010, 1, 1, "R5");
    check("R5", walk_req, 1);
    fill(48'h0000_0009_9000, 28'h00777, 0, 1, 1, 1);
    look(48'h0000_0009_9010, 1, 1, "R8");
    step(0, '0, 0, 0, 0, '0, '0, 0, 0, 0, 0, 0, '0, 0, "R6");
    // R9: invalidate inside the 2 MB page
    step(0, '0, 0, 0, 0, '0, '0, 0, 0, 0, 0, 1, 48'h0000_403F_0000, 0, "R9");
    look(48'h0000_4020_0000, 0, 0, "R9");
    look(48'h0000_1234_5678, 0, 0, "R9");
    look(48'h0080_4000_0000, 0, 0, "R9");
    // R10: flush with a coincident fill
    step(0, '0, 0, 0, 1, 48'h0000_5555_5000, 28'h5, 0, 1, 1, 1, 0, '0, 1, "R10");
    look(48'h0000_5555_5000, 0, 0, "R10");
    look(48'h0000_1234_5678, 0, 0, "R10");
    // R8: fill every slot, then evict round robin
    for (int i = 0; i < N + 2; i++)
      fill(48'h0001_0000_0000 + 48'(i) * 48'h1000, 28'(i), 0, 1, 1, 1);
    look(48'h0001_0000_0000, 0, 0, "R8");
    look(48'h0001_0000_1000, 0, 0, "R8");
    look(48'h0001_0000_2000, 0, 0, "R8");
    look(48'h0001_0002_1000, 0, 0, "R8");
    step(0, '0, 0, 0, 0, '0, '0, 0, 0, 0, 0, 0, '0, 1, "R10");
    // constrained random mix against the model
    for (int k = 0; k < 3000; k++) begin
      int op = $urandom % 16;
      step(($urandom % 4) != 0, rva(), $urandom % 2, $urandom % 2,
           op < 5, rva(), 28'($urandom), 2'($urandom % 3),
           $urandom % 2, $urandom % 2, ($urandom % 3) != 0,
           op == 5, rva(), op == 6 && ($urandom % 8) == 0, "R3");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule